// File: doc/BRIEF.md
# I2C Bus Master START Generator

This block produces the START condition for an I2C bus master: with both lines idle, it pulls SDA low while SCL stays released. Software sets a start-enable bit in a five-bit command field. The block checks that both bus lines are high, waits one baud period, checks the lines again and then pulls SDA low. It then waits a second baud period and finishes. At that point it clears the start-enable bit and raises a completion flag. SDA stays held low so that the first data bit can follow.

A single down-counter sets the length of both periods. It loads from a 7-bit reload value. The open-drain lines are read through a two-flop synchronizer. The block also watches the bus for other masters. If it sees a low line where the bus must be idle, it raises a bus-collision flag, drops the request and releases SDA. While a START is running, it locks out buffer writes and further command writes, so that commands cannot pile up.

Top module: `i2c_start_gen`

## Requirements
- R1: A command write with bit 0 (start enable) set, made while no START is running and with both synchronized lines high, sets `cmd_q[0]` on the accepting edge. SDA stays released during the first period.
- R2: A period lasts `reload`+1 clock edges, with `reload` from 0 to 127. SDA is driven low (`sda_oe`=1) after the edge that ends the first period. `scl_oe` stays 0 at all times.
- R3: `start_seen` rises on the same edge that SDA is first driven low. It is cleared when a new request is accepted.
- R4: When the second period ends, `cmd_q[0]` clears, `done_flag` sets and SDA stays driven low with the counter stopped until a later request.
- R5: A start request made while either synchronized line is low sets `bcol_flag`. In that case `cmd_q[0]` is not set and SDA stays released.
- R6: SCL low at any point during the first period, or SDA low when the first period ends, aborts the START. The abort sets `bcol_flag`, clears `cmd_q[0]` and releases SDA. SCL low during the second period has no effect.
- R7: A buffer write while `cmd_q[0]` is set sets `wcol_flag` and leaves `buf_q` unchanged. At other times the write loads `buf_q` and leaves `wcol_flag` as it was.
- R8: Command writes while `cmd_q[0]` is set are ignored, so all five bits of `cmd_q` keep their values. At other times a command write loads all five bits.
- R9: `done_flag`, `bcol_flag` and `wcol_flag` are sticky. A flag write clears each flag whose `flag_wdata` bit is 0 (bit 0 done, bit 1 collision, bit 2 write collision). A bit of 1 leaves its flag as it was. A hardware set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload | input | 7 | Baud counter reload value |
| cmd_wr | input | 1 | Command field write strobe |
| cmd_wdata | input | 5 | Command write data, bit 0 is start enable |
| cmd_q | output | 5 | Command field readback |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Transmit buffer write data |
| buf_q | output | 8 | Transmit buffer contents |
| flag_wr | input | 1 | Flag clear write strobe |
| flag_wdata | input | 3 | Flag write data; 0 clears the flag |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 (always 0 here) |
| start_seen | output | 1 | START driven on the bus |
| done_flag | output | 1 | START completion flag |
| bcol_flag | output | 1 | Bus collision flag |
| wcol_flag | output | 1 | Write collision flag |

## Verification
The START is run on an idle bus for every reload value from 0 to 15 and for 127. Exact edge counts for the SDA fall and for completion separate an off-by-one in either period from a counter that does not reload. Collision runs pull SCL low early, pull SDA low mid-period, hold either line low at the request, and pull SCL low in the second period. Together these separate live SCL sampling, the SDA check at expiry and the window in which collisions count. Buffer, command and flag writes are made both while busy and while idle, to show the lockout and the sticky clear.

// File: rtl/i2c_start_gen.sv
module i2c_start_gen #(
  parameter int RW = 7,
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] reload,
  input  logic          cmd_wr,
  input  logic [CW-1:0] cmd_wdata,
  output logic [CW-1:0] cmd_q,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  output logic [DW-1:0] buf_q,
  input  logic          flag_wr,
  input  logic [2:0]    flag_wdata,
  input  logic          sda_in,
  input  logic          scl_in,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic          start_seen,
  output logic          done_flag,
  output logic          bcol_flag,
  output logic          wcol_flag
);
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_LOW, ST_HOLD} st_t;

  st_t          st;
  logic [RW-1:0] cnt;
  logic [1:0]   sda_sy, scl_sy;
  logic         sda_ok, scl_ok, busy, expire;

  assign sda_ok = sda_sy[1];
  assign scl_ok = scl_sy[1];
  assign busy   = (st == ST_PRE) || (st == ST_LOW);
  assign expire = (cnt == '0);
  assign sda_oe = (st == ST_LOW) || (st == ST_HOLD);
  assign scl_oe = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sy <= 2'b11;
      scl_sy <= 2'b11;
    end else begin
      sda_sy <= {sda_sy[0], sda_in};
      scl_sy <= {scl_sy[0], scl_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      cmd_q      <= '0;
      buf_q      <= '0;
      start_seen <= 1'b0;
      done_flag  <= 1'b0;
      bcol_flag  <= 1'b0;
      wcol_flag  <= 1'b0;
    end else begin
      if (flag_wr) begin
        done_flag <= done_flag & flag_wdata[0];
        bcol_flag <= bcol_flag & flag_wdata[1];
        wcol_flag <= wcol_flag & flag_wdata[2];
      end

      if (buf_wr) begin
        if (busy) wcol_flag <= 1'b1;
        else      buf_q     <= buf_wdata;
      end

      case (st)
        ST_IDLE, ST_HOLD: begin
          if (cmd_wr) begin
            cmd_q <= cmd_wdata;
            if (cmd_wdata[0]) begin
              if (sda_ok && scl_ok) begin
                st         <= ST_PRE;
                cnt        <= reload;
                start_seen <= 1'b0;
              end else begin
                st        <= ST_IDLE;
                cmd_q[0]  <= 1'b0;
                bcol_flag <= 1'b1;
              end
            end
          end
        end
        ST_PRE: begin
          if (!scl_ok || (expire && !sda_ok)) begin
            st        <= ST_IDLE;
            cmd_q[0]  <= 1'b0;
            bcol_flag <= 1'b1;
          end else if (expire) begin
            st         <= ST_LOW;
            cnt        <= reload;
            start_seen <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (expire) begin
            st        <= ST_HOLD;
            cmd_q[0]  <= 1'b0;
            done_flag <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk #(
  parameter int CW = 5,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wr,
  input logic [CW-1:0] cmd_q,
  input logic          buf_wr,
  input logic [DW-1:0] buf_q,
  input logic          sda_oe,
  input logic          start_seen,
  input logic          done_flag,
  input logic          bcol_flag,
  input logic          wcol_flag
);
  AST_SEEN_WITH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $rose(start_seen)); // R3
  AST_DONE_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> (!cmd_q[0] && sda_oe)); // R4
  AST_COLL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol_flag) |-> (!cmd_q[0] && !sda_oe)); // R6
  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[0] && cmd_wr) |=> $stable(cmd_q[CW-1:1])); // R8
  AST_WCOL_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[0] && buf_wr) |=> (wcol_flag && $stable(buf_q))); // R7
endmodule

bind i2c_start_gen i2c_start_gen_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_q(cmd_q),
  .buf_wr(buf_wr), .buf_q(buf_q), .sda_oe(sda_oe),
  .start_seen(start_seen), .done_flag(done_flag),
  .bcol_flag(bcol_flag), .wcol_flag(wcol_flag)
);

// File: tb/i2c_start_gen_bench.sv
module i2c_start_gen_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [6:0] reload = '0;
  logic       cmd_wr = 1'b0, buf_wr = 1'b0, flag_wr = 1'b0;
  logic [4:0] cmd_wdata = '0, cmd_q;
  logic [7:0] buf_wdata = '0, buf_q;
  logic [2:0] flag_wdata = '0;
  logic       ext_sda = 1'b1, ext_scl = 1'b1;
  logic       sda_in, scl_in, sda_oe, scl_oe;
  logic       start_seen, done_flag, bcol_flag, wcol_flag;
  int         n_run = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  assign sda_in = ext_sda & ~sda_oe;
  assign scl_in = ext_scl & ~scl_oe;

  i2c_start_gen u_i2c_start_gen (
    .clk(clk), .rst_n(rst_n), .reload(reload),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_q(cmd_q),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_q(buf_q),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .start_seen(start_seen), .done_flag(done_flag),
    .bcol_flag(bcol_flag), .wcol_flag(wcol_flag)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ext_sda = 1'b1; ext_scl = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // write the command field; returns at the negedge just after the accepting edge
  task automatic wr_cmd(logic [4:0] d);
    cmd_wr = 1'b1; cmd_wdata = d;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wr_buf(logic [7:0] d);
    buf_wr = 1'b1; buf_wdata = d;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic wr_flag(logic [2:0] d);
    flag_wr = 1'b1; flag_wdata = d;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset cmd_q", cmd_q, 0);
    chk("R2 reset sda_oe", sda_oe, 0);
    chk("R9 reset flags", {done_flag, bcol_flag, wcol_flag, start_seen}, 0);

    // Timing sweep over reload values
    for (int r = 0; r <= 16; r++) begin
      int rv = (r == 16) ? 127 : r;
      do_reset();
      reload = 7'(rv);
      wr_cmd(5'b00001);                    // n = 1
      chk("R1 accepted", cmd_q[0], 1);
      chk("R1 sda released", sda_oe, 0);
      for (int n = 2; n <= 2*rv + 3; n++) begin
        @(negedge clk);
        if (n == rv + 1) chk("R2 sda still released", sda_oe, 0);
        if (n == rv + 2) begin
          chk("R2 sda driven low", sda_oe, 1);
          chk("R3 start_seen", start_seen, 1);
        end
        if (n == 2*rv + 2) chk("R4 still busy", {cmd_q[0], done_flag}, 2'b10);
      end
      chk("R4 complete", {cmd_q[0], done_flag, sda_oe}, 3'b011);
      chk("R2 scl never driven", scl_oe, 0);
    end
    repeat (20) @(negedge clk);
    chk("R4 sda held", sda_oe, 1);
    chk("R9 done sticky", done_flag, 1);
    wr_cmd(5'b00001);   // new request in hold: SDA is low -> collision
    chk("R5 request from hold", {bcol_flag, cmd_q[0], sda_oe}, 3'b100);

    // Collision at request
    do_reset(); ext_scl = 1'b0; repeat (3) @(negedge clk);
    wr_cmd(5'b00001);
    chk("R5 scl low at request", {bcol_flag, cmd_q[0], sda_oe}, 3'b100);
    do_reset(); ext_sda = 1'b0; repeat (3) @(negedge clk);
    wr_cmd(5'b00001);
    chk("R5 sda low at request", {bcol_flag, cmd_q[0], sda_oe}, 3'b100);

    // SCL low mid first period
    do_reset(); reload = 7'd6;
    wr_cmd(5'b00001);                       // n=1
    @(negedge clk); ext_scl = 1'b0;         // n=2
    repeat (5) @(negedge clk);              // n=7
    chk("R6 scl low aborts", {bcol_flag, cmd_q[0], sda_oe}, 3'b100);
    repeat (4) @(negedge clk);
    chk("R6 stays idle", sda_oe, 0);

    // SDA low during first period: only matters at expiry
    do_reset(); reload = 7'd6;
    wr_cmd(5'b00001);
    @(negedge clk); ext_sda = 1'b0;         // n=2
    repeat (3) @(negedge clk);              // n=5
    chk("R6 sda low before expiry", {bcol_flag, cmd_q[0]}, 2'b01);
    repeat (4) @(negedge clk);              // n=9
    chk("R6 sda low at expiry", {bcol_flag, cmd_q[0], sda_oe}, 3'b100);

    // SCL low during second period ignored
    do_reset(); reload = 7'd3;
    wr_cmd(5'b00001);
    repeat (4) @(negedge clk);              // n=5
    chk("R6 low driven", sda_oe, 1);
    ext_scl = 1'b0;
    repeat (4) @(negedge clk);              // n=9
    chk("R6 second period unaffected", {bcol_flag, done_flag, cmd_q[0]}, 3'b010);

    // Buffer lockout and command lockout
    do_reset(); reload = 7'd10;
    wr_buf(8'h55);
    chk("R7 idle buffer write", {wcol_flag, buf_q}, {1'b0, 8'h55});
    wr_cmd(5'b10100);
    chk("R8 idle command write", cmd_q, 5'b10100);
    wr_cmd(5'b00001);
    chk("R8 start loads all bits", cmd_q, 5'b00001);
    wr_buf(8'hAA);
    chk("R7 busy buffer write", {wcol_flag, buf_q}, {1'b1, 8'h55});
    wr_cmd(5'b11110);
    chk("R8 busy command ignored", cmd_q, 5'b00001);
    repeat (30) @(negedge clk);
    chk("R4 done after lockout", done_flag, 1);
    wr_buf(8'hC3);
    chk("R7 buffer after done", buf_q, 8'hC3);

    // Sticky flags and clearing; make collision flag set too
    wr_cmd(5'b00001);                       // in hold -> collision
    chk("R9 all flags set", {wcol_flag, bcol_flag, done_flag}, 3'b111);
    wr_flag(3'b110);
    chk("R9 clear done only", {wcol_flag, bcol_flag, done_flag}, 3'b110);
    wr_flag(3'b111);
    chk("R9 ones keep", {wcol_flag, bcol_flag, done_flag}, 3'b110);
    wr_flag(3'b000);
    chk("R9 clear all", {wcol_flag, bcol_flag, done_flag}, 3'b000);
    // set wins over clear in same cycle
    ext_scl = 1'b0; repeat (3) @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = 5'b00001; flag_wr = 1'b1; flag_wdata = 3'b000;
    @(negedge clk);
    cmd_wr = 1'b0; flag_wr = 1'b0;
    chk("R9 set beats clear", bcol_flag, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule